// File: doc/BRIEF.md
# Clock-Synchronous Serial Transmitter with Steerable Transfer Clock

This block sends bytes on a single data line, together with a transfer clock that it makes itself from the system clock. Software writes a byte into a holding buffer. While the transmitter is enabled, the byte is copied into a shift register on the first active edge of the transfer clock and then leaves one bit per transfer-clock period. When a byte finishes and no further byte is waiting, the transfer clock stops at its idle level and a sticky interrupt request is raised. If the interrupt is set to follow the buffer instead, the request is raised at the moment the buffer is copied.

The transfer clock goes out on one of four clock pins, chosen by a two-bit select field. Pins that are not selected stay high. A change to the select field takes effect only while no byte is being shifted. A clear-to-send input (active low) can hold back the start of a byte, but it is obeyed only while the clock goes out on the primary pin (select 00). Steering the clock to any other pin makes the block ignore clear-to-send.

Configuration covers four settings for the bit stream: the prescaler (system clock divided by 1, 8 or 32 per half period of the transfer clock), the clock polarity, the bit order and the inversion of data and line. A fifth setting picks the interrupt source.

Top module: `sync_tx_steer`

## Requirements
- R1: Mode register (address 1) bit 0 enables the transmitter. While it is 0, a byte written to the buffer (address 0) is kept, buf_empty stays 0 and no transfer clock appears. Setting the bit later starts that byte.
- R2: A byte is copied from the buffer into the shift register on the first active clock edge after it becomes eligible. In that same cycle buf_empty goes to 1, the selected clock pin leaves its idle level and txd shows the first bit.
- R3: Mode bit 3 selects the clock polarity. With 0, the selected pin idles high and data changes on its falling edges. With 1, the pin output is inverted: it idles low and data changes on its rising edges.
- R4: Mode bit 4 selects the bit order: 0 sends bit 0 first, 1 sends bit 7 first.
- R5: Once a byte starts, its eight bits last exactly 16 half periods. If no further byte starts, txreg_empty then goes to 1 and the clock rests at its idle level. After reset, txreg_empty is 1.
- R6: Mode bits 2:1 set the half period of the transfer clock: 00 gives 1 system cycle, 01 gives 8 and 10 or 11 gives 32. Successive active edges within a byte are two half periods apart.
- R7: Route register (address 2) bits 2:1 select the clock pin: clk_pins[0] for 00, clk_pins[1] for 01, clk_pins[2] for 10 and clk_pins[3] for 11. Every pin that is not selected stays 1.
- R8: Route register bit 0 enables clear-to-send. While it is 1 and the select field is 00, a byte starts only while cts_n is 0. With any other select value, cts_n has no effect.
- R9: Mode bit 7 selects the interrupt source. With 1, irq is set when the buffer is copied into the shift register. With 0, irq is set when a byte completes with no successor.
- R10: Mode bit 5 inverts each data bit sent. Mode bit 6 inverts the whole txd line. The idle line level is 1, or 0 when bit 6 is set.
- R11: A write to the select field takes effect only once the transmitter is idle. During a byte, the clock stays on the previously selected pin.
- R12: A byte written while another is shifting follows it back to back. Its first active edge comes one half period after the last bit's trailing edge, and txreg_empty stays 0 in between.
- R13: irq stays 1 until a write to address 3 clears it. A new interrupt event in the same cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 buffer, 1 mode, 2 route, 3 interrupt clear |
| wr_data | input | DATA_W | Write data |
| cts_n | input | 1 | Clear-to-send, active low |
| txd | output | 1 | Serial data line |
| clk_pins | output | 4 | Transfer clock outputs, one active at a time |
| buf_empty | output | 1 | Holding buffer is empty |
| txreg_empty | output | 1 | Shift register is empty (no byte in flight) |
| irq | output | 1 | Sticky transmit interrupt request |

## Verification
Properties are checked on every cycle. Each load has to meet its preconditions: the transmitter enabled, the buffer full, and clear-to-send asserted when it is enabled on the primary pin. At most one clock pin may be low at a time. The applied select may not change while a byte is in flight. The interrupt has to follow its chosen source and its clear. Only the bench's scenarios can show that the serial stream has the right content: bit order, both inversions and both polarities with random data on every pin. The same holds for the exact half-period spacing, the byte length in cycles, the back-to-back join without an idle gap, and the deferred clock steering seen on the pins.

// File: rtl/sync_tx_pkg.sv
package sync_tx_pkg;

    localparam int SEL_W    = 2;
    localparam int NUM_PINS = 1 << SEL_W;
    localparam int DIV_MID  = 8;
    localparam int DIV_SLOW = 32;
    localparam int CNT_W    = $clog2(DIV_SLOW);

    typedef enum logic [1:0] {
        ADDR_BUF   = 2'd0,
        ADDR_MODE  = 2'd1,
        ADDR_ROUTE = 2'd2,
        ADDR_ACK   = 2'd3
    } reg_addr_e;

    // Mode register image, bit 7 down to bit 0.
    typedef struct packed {
        logic       irq_on_empty;
        logic       line_inv;
        logic       data_inv;
        logic       msb_first;
        logic       lead_rise;
        logic [1:0] presc;
        logic       tx_en;
    } mode_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } sh_state_e;

    function automatic logic [CNT_W:0] div_of(input logic [1:0] presc);
        case (presc)
            2'b00:   div_of = (CNT_W+1)'(1);
            2'b01:   div_of = (CNT_W+1)'(DIV_MID);
            default: div_of = (CNT_W+1)'(DIV_SLOW);
        endcase
    endfunction

endpackage

// File: rtl/sync_tx_regs.sv
module sync_tx_regs
    import sync_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              load,
    input  logic              done,
    input  logic              busy,
    output mode_t             mode_o,
    output logic [SEL_W-1:0]  sel_act_o,
    output logic              cts_en_o,
    output logic [DATA_W-1:0] buf_o,
    output logic              buf_empty_o,
    output logic              irq_o
);

    logic [SEL_W-1:0] sel_pend;
    logic wr_buf, wr_mode, wr_route, wr_ack, irq_set;

    always_comb begin
        wr_buf   = wr_en && (reg_addr_e'(wr_addr) == ADDR_BUF);
        wr_mode  = wr_en && (reg_addr_e'(wr_addr) == ADDR_MODE);
        wr_route = wr_en && (reg_addr_e'(wr_addr) == ADDR_ROUTE);
        wr_ack   = wr_en && (reg_addr_e'(wr_addr) == ADDR_ACK);
        irq_set  = mode_o.irq_on_empty ? load : done;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_o      <= '0;
            sel_pend    <= '0;
            sel_act_o   <= '0;
            cts_en_o    <= 1'b0;
            buf_o       <= '0;
            buf_empty_o <= 1'b1;
            irq_o       <= 1'b0;
        end else begin
            if (wr_mode) begin
                mode_o <= mode_t'(wr_data[7:0]);
            end
            if (wr_route) begin
                sel_pend <= wr_data[SEL_W:1];
                cts_en_o <= wr_data[0];
            end
            // Steering is applied only between bytes.
            if (!busy) begin
                sel_act_o <= sel_pend;
            end
            if (wr_buf) begin
                buf_o       <= wr_data;
                buf_empty_o <= 1'b0;
            end else if (load) begin
                buf_empty_o <= 1'b1;
            end
            if (irq_set) begin
                irq_o <= 1'b1;
            end else if (wr_ack) begin
                irq_o <= 1'b0;
            end
        end
    end

    assert_sel_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (sel_act_o != $past(sel_act_o)) |-> !$past(busy));

    assert_irq_empty_R9: assert property (@(posedge clk) disable iff (rst)
        (load && mode_o.irq_on_empty) |=> irq_o);

    assert_irq_ack_R13: assert property (@(posedge clk) disable iff (rst)
        (wr_ack && !irq_set) |=> !irq_o);

    assert_buf_fill_R2: assert property (@(posedge clk) disable iff (rst)
        wr_buf |=> !buf_empty_o);

endmodule

// File: rtl/sync_tx_div.sv
module sync_tx_div
    import sync_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic [1:0] presc,
    output logic       tick
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   div_val;

    always_comb begin
        div_val = div_of(presc);
        tick    = !clear && ({1'b0, cnt} == div_val - 1'b1);
    end

    always_ff @(posedge clk) begin
        if (rst || clear || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assert_tick_gap_R6: assert property (@(posedge clk) disable iff (rst)
        (tick && div_val != 1) |=> (!tick || div_val == 1));

endmodule

// File: rtl/sync_tx_shifter.sv
module sync_tx_shifter
    import sync_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              tx_en,
    input  logic              cts_en,
    input  logic [SEL_W-1:0]  sel_act,
    input  logic              cts_n,
    input  logic              buf_empty,
    input  logic [DATA_W-1:0] buf_data,
    input  logic              msb_first,
    output logic              load,
    output logic              done,
    output logic              busy,
    output logic              sck_int,
    output logic              bit_o,
    output logic              txreg_empty
);

    localparam int BIT_W = $clog2(DATA_W);
    localparam logic [BIT_W-1:0] LAST = BIT_W'(DATA_W - 1);

    sh_state_e         state;
    logic [DATA_W-1:0] shreg;
    logic [BIT_W-1:0]  bit_cnt;
    logic              msb_l;
    logic              start_ok, byte_end;

    always_comb begin
        start_ok = tx_en && !buf_empty && (!cts_en || (sel_act != '0) || !cts_n);
        byte_end = (state == ST_HIGH) && tick && (bit_cnt == LAST);
        load     = start_ok && ((state == ST_IDLE) || byte_end);
        done     = byte_end && !start_ok;
        busy     = (state != ST_IDLE);
        sck_int  = (state != ST_LOW);
        bit_o    = msb_l ? shreg[DATA_W-1] : shreg[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            shreg       <= '0;
            bit_cnt     <= '0;
            msb_l       <= 1'b0;
            txreg_empty <= 1'b1;
        end else if (load) begin
            state       <= ST_LOW;
            shreg       <= buf_data;
            bit_cnt     <= '0;
            msb_l       <= msb_first;
            txreg_empty <= 1'b0;
        end else begin
            case (state)
                ST_LOW: begin
                    if (tick) state <= ST_HIGH;
                end
                ST_HIGH: begin
                    if (tick) begin
                        if (bit_cnt == LAST) begin
                            state       <= ST_IDLE;
                            txreg_empty <= 1'b1;
                        end else begin
                            shreg   <= msb_l ? (shreg << 1) : (shreg >> 1);
                            bit_cnt <= bit_cnt + 1'b1;
                            state   <= ST_LOW;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_load_enabled_R1: assert property (@(posedge clk) disable iff (rst)
        load |-> tx_en);

    assert_load_full_R2: assert property (@(posedge clk) disable iff (rst)
        load |-> !buf_empty);

    assert_cts_gate_R8: assert property (@(posedge clk) disable iff (rst)
        (load && cts_en && sel_act == '0) |-> !cts_n);

    assert_idle_rest_R5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> (sck_int && txreg_empty));

endmodule

// File: rtl/sync_tx_steer.sv
module sync_tx_steer
    import sync_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [1:0]          wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                cts_n,
    output logic                txd,
    output logic [NUM_PINS-1:0] clk_pins,
    output logic                buf_empty,
    output logic                txreg_empty,
    output logic                irq
);

    mode_t             mode;
    logic [SEL_W-1:0]  sel_act;
    logic              cts_en;
    logic [DATA_W-1:0] buf_data;
    logic              load, done, busy, sck_int, bit_raw, tick;

    sync_tx_regs #(.DATA_W(DATA_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .load        (load),
        .done        (done),
        .busy        (busy),
        .mode_o      (mode),
        .sel_act_o   (sel_act),
        .cts_en_o    (cts_en),
        .buf_o       (buf_data),
        .buf_empty_o (buf_empty),
        .irq_o       (irq)
    );

    sync_tx_div u_div (
        .clk   (clk),
        .rst   (rst),
        .clear (!busy),
        .presc (mode.presc),
        .tick  (tick)
    );

    sync_tx_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .tx_en       (mode.tx_en),
        .cts_en      (cts_en),
        .sel_act     (sel_act),
        .cts_n       (cts_n),
        .buf_empty   (buf_empty),
        .buf_data    (buf_data),
        .msb_first   (mode.msb_first),
        .load        (load),
        .done        (done),
        .busy        (busy),
        .sck_int     (sck_int),
        .bit_o       (bit_raw),
        .txreg_empty (txreg_empty)
    );

    // Data inversion touches only bits in flight; line inversion touches all.
    always_comb begin
        txd = (busy ? (bit_raw ^ mode.data_inv) : 1'b1) ^ mode.line_inv;
    end

    for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_pin
        assign clk_pins[gi] = (sel_act == SEL_W'(gi)) ? (sck_int ^ mode.lead_rise) : 1'b1;
    end

    assert_one_low_pin_R7: assert property (@(posedge clk) disable iff (rst)
        $countones(~clk_pins) <= 1);

endmodule

// File: tb/sync_tx_steer_bench.sv
module sync_tx_steer_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       cts_n = 1'b0;
    logic       txd;
    logic [3:0] pins;
    logic       buf_empty, txreg_empty, irq;

    always #4 clk = ~clk;

    sync_tx_steer u_sync_tx_steer (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .cts_n       (cts_n),
        .txd         (txd),
        .clk_pins    (pins),
        .buf_empty   (buf_empty),
        .txreg_empty (txreg_empty),
        .irq         (irq)
    );

    int errors = 0, checks = 0, cyc = 0;
    int mon_sel = 0, mon_div = 1;
    logic mon_pol = 1'b0, mon_int, prev_int = 1'b1, prev_te = 1'b1;
    int bitidx = 0, nbytes = 0, last_lead = 0, first_gap = 0, te_rise = 0;
    int pin_err = 0, sp_err = 0;
    logic [7:0] cap, last_got;
    int start_cyc [128];

    // Serial monitor: decodes whatever appears on the expected pin.
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            for (int i = 0; i < 4; i++)
                if (i != mon_sel && pins[i] !== 1'b1) pin_err++;
            mon_int = pins[mon_sel] ^ mon_pol;
            if (prev_int && !mon_int) begin
                if (bitidx == 0) begin
                    if (nbytes < 128) start_cyc[nbytes] = cyc;
                end else begin
                    if (bitidx == 1) first_gap = cyc - last_lead;
                    if (cyc - last_lead != 2 * mon_div) sp_err++;
                end
                last_lead = cyc;
            end
            if (!prev_int && mon_int) begin
                cap[bitidx[2:0]] = txd;
                if (bitidx == 7) begin
                    last_got = cap;
                    nbytes++;
                    bitidx = 0;
                end else begin
                    bitidx++;
                end
            end
            if (!prev_te && txreg_empty) te_rise = cyc;
            prev_int = mon_int;
            prev_te  = txreg_empty;
        end
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int divf(input logic [1:0] p);
        return (p == 2'b00) ? 1 : (p == 2'b01) ? 8 : 32;
    endfunction

    function automatic logic [7:0] exp_line(input logic [7:0] d, input logic msb,
                                             input logic dinv, input logic linv);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = (msb ? d[7-i] : d[i]) ^ dinv ^ linv;
        return r;
    endfunction

    function automatic logic [7:0] mb(input logic en, input logic [1:0] presc, input logic pol,
                                      input logic msb, input logic dinv, input logic linv,
                                      input logic ie);
        return {ie, linv, dinv, msb, pol, presc, en};
    endfunction

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a[1:0]; wr_data = d;
        @(posedge clk);
        if (a == 1) begin
            mon_pol = d[3];
            mon_div = divf(d[2:1]);
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_route(input int sel, input logic cts);
        wr(2, {5'd0, sel[1:0], cts});
        @(posedge clk);
        mon_sel = sel;
    endtask

    task automatic wait_idle();
        while (!(txreg_empty && buf_empty)) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic wait_bytes(input int n);
        while (nbytes < n) @(negedge clk);
    endtask

    task automatic send(input string req, input logic [7:0] d, input logic msb,
                        input logic dinv, input logic linv);
        int n;
        n = nbytes;
        wr(0, d);
        wait_bytes(n + 1);
        chk(req, last_got, exp_line(d, msb, dinv, linv));
        wait_idle();
    endtask

    initial begin
        int n;
        logic [1:0] presc;
        logic pol, msb, dinv, linv;
        logic [7:0] d;
        int sel;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        chk("R5 reset txreg_empty", txreg_empty, 1);
        chk("R2 reset buf_empty", buf_empty, 1);
        chk("R7 reset pins", pins, 4'hF);
        chk("R10 reset txd", txd, 1);
        chk("R13 reset irq", irq, 0);

        // R1: disabled transmitter holds the byte
        set_route(0, 1'b0);
        wr(1, mb(1'b0, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
        wr(0, 8'hA5);
        repeat (60) @(negedge clk);
        chk("R1 no byte while disabled", nbytes, 0);
        chk("R1 buffer kept", buf_empty, 0);
        chk("R1 clock idle", pins[0], 1);
        wr(1, mb(1'b1, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
        wait_bytes(1);
        chk("R1 byte after enable", last_got, exp_line(8'hA5, 1'b0, 1'b0, 1'b0));
        wait_idle();
        chk("R5 byte length", te_rise - start_cyc[0], 16 * 8);
        chk("R6 div8 edge spacing", first_gap, 16);
        chk("R5 clock rests high", pins[0], 1);

        // R2: first bit and empty buffer at the load edge
        wr(0, 8'h01);
        while (!buf_empty) @(negedge clk);
        chk("R2 clock low at load", pins[0], 0);
        chk("R2 first bit at load", txd, 1);
        chk("R2 txreg busy at load", txreg_empty, 0);
        wait_idle();

        // R4: MSB first, div1
        wr(1, mb(1'b1, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0));
        send("R4 msb first", 8'hC1, 1'b1, 1'b0, 1'b0);
        chk("R6 div1 edge spacing", first_gap, 2);

        // R10: inversions
        wr(1, mb(1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0));
        @(negedge clk);
        chk("R10 idle line inverted", txd, 0);
        send("R10 line invert", 8'h5A, 1'b0, 1'b0, 1'b1);
        wr(1, mb(1'b1, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0));
        @(negedge clk);
        chk("R10 idle with data invert", txd, 1);
        send("R10 data invert", 8'h5A, 1'b0, 1'b1, 1'b0);

        // R3: rising-edge polarity
        wr(1, mb(1'b1, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0));
        @(negedge clk);
        chk("R3 idle clock low", pins[0], 0);
        send("R3 rising polarity", 8'h96, 1'b0, 1'b0, 1'b0);
        chk("R3 clock back low", pins[0], 0);

        // R8: clear-to-send
        wr(1, mb(1'b1, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
        set_route(0, 1'b1);
        cts_n = 1'b1;
        n = nbytes;
        wr(0, 8'h3C);
        repeat (80) @(negedge clk);
        chk("R8 held by cts", nbytes, n);
        chk("R8 buffer still full", buf_empty, 0);
        cts_n = 1'b0;
        wait_bytes(n + 1);
        chk("R8 byte after cts", last_got, exp_line(8'h3C, 1'b0, 1'b0, 1'b0));
        wait_idle();
        cts_n = 1'b1;
        set_route(3, 1'b1);
        send("R8 cts ignored on steered pin", 8'hE7, 1'b0, 1'b0, 1'b0);
        set_route(0, 1'b0);
        cts_n = 1'b0;

        // R9 / R13: interrupt sources and clear
        wr(1, mb(1'b1, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1));
        wr(3, 8'h00);
        chk("R13 irq cleared", irq, 0);
        wr(0, 8'h11);
        repeat (3) @(negedge clk);
        chk("R9 irq on buffer empty", irq, 1);
        chk("R9 byte still shifting", txreg_empty, 0);
        wait_idle();
        wr(3, 8'h00);
        chk("R13 irq cleared again", irq, 0);
        wr(1, mb(1'b1, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
        wr(0, 8'h22);
        repeat (3) @(negedge clk);
        chk("R9 no irq before completion", irq, 0);
        wait_idle();
        chk("R9 irq on completion", irq, 1);
        wr(3, 8'h00);

        // R11: deferred steering
        n = nbytes;
        wr(0, 8'h69);
        repeat (20) @(negedge clk);
        wr(2, 8'b0000_0100);
        repeat (10) @(negedge clk);
        chk("R11 new pin idle mid byte", pins[2], 1);
        wait_bytes(n + 1);
        chk("R11 byte stayed on old pin", last_got, exp_line(8'h69, 1'b0, 1'b0, 1'b0));
        wait_idle();
        mon_sel = 2;
        send("R11 clock on new pin", 8'h4B, 1'b0, 1'b0, 1'b0);
        set_route(0, 1'b0);

        // R12: back to back at div1
        wr(1, mb(1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
        n = nbytes;
        wr(0, 8'hF0);
        while (!buf_empty) @(negedge clk);
        wr(0, 8'h0F);
        wait_bytes(n + 1);
        chk("R12 first byte", last_got, exp_line(8'hF0, 1'b0, 1'b0, 1'b0));
        wait_bytes(n + 2);
        chk("R12 second byte", last_got, exp_line(8'h0F, 1'b0, 1'b0, 1'b0));
        wait_idle();
        chk("R12 no idle gap", start_cyc[n+1] - start_cyc[n], 16);
        chk("R12 txreg busy across join", te_rise - start_cyc[n], 32);

        // Random configurations
        for (int k = 0; k < 20; k++) begin
            presc = 2'($urandom % 3);
            pol   = 1'($urandom % 2);
            msb   = 1'($urandom % 2);
            dinv  = 1'($urandom % 2);
            linv  = 1'($urandom % 2);
            sel   = int'($urandom % 4);
            d     = 8'($urandom % 256);
            set_route(sel, 1'b0);
            wr(1, mb(1'b1, presc, pol, msb, dinv, linv, 1'b0));
            send("R4 R7 R10 random byte", d, msb, dinv, linv);
            chk("R6 random edge spacing", first_gap, 2 * divf(presc));
        end

        chk("R7 unselected pins high", pin_err, 0);
        chk("R6 spacing within bytes", sp_err, 0);
        summary();
        $finish;
    end

endmodule